// File: doc/BRIEF.md
# Snooping Five-State Cache Coherence Controller

This block keeps a set of private caches coherent on one shared bus. Each cache holds a per-line coherence state drawn from five values: Invalid, Shared, Exclusive, Owned and Modified. Processors post read, write, evict or no-op requests against a line index. A round-robin arbiter picks one requester per cycle. The chosen cache issues a bus command (read, read-for-ownership, invalidate or none). Every other cache snoops that command and updates its copy of the line.

Each cache broadcasts its state for the line on the bus (the snoop reply) to the bus logic. From these replies the bus logic decides four things: which peer supplies the data, whether the memory read is aborted, whether the requester's new state is Shared or Exclusive, and whether evicting a dirty line needs a write-back. Dirty data can move between caches through the Owned state without updating memory. Data arrays, tags and replacement are outside the block: a line index stands for an address. A probe port reads any cache's line state.

Top module: `coh_snoop_bus`

## Requirements
- R1: After reset every line of every cache is Invalid. No grant is given. `bus_vld`, `bus_cmd`, `bus_supplier`, `mem_abort` and `wb_req` are all zero.
- R2: Line states use 3 bits: Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4. Bus commands use 2 bits: none=0, read=1, read-for-ownership=2, invalidate=3. Processor ops use 2 bits: read=0, write=1, evict=2, no-op=3.
- R3: A read on an Invalid line issues a read command. The requester becomes Exclusive when no peer holds the line in any valid state, and Shared otherwise.
- R4: A snooped read moves a peer's line from Modified to Owned and from Exclusive to Shared. Owned and Shared stay as they are.
- R5: On a read or read-for-ownership, `mem_abort` is 1 exactly when some peer holds the line valid. `bus_supplier` is one-hot and picks the first of these that exists: the Modified/Owned peer, the Exclusive peer, the lowest-index Shared peer. When no peer holds the line, `bus_supplier` is zero. Other commands leave both signals zero.
- R6: A write on Shared or Owned issues an invalidate. A write on Invalid issues read-for-ownership. A write on Exclusive issues no command. In all of these cases, and when the line is already Modified, the requester ends in Modified.
- R7: A snooped read-for-ownership or invalidate sets every peer's copy of the line to Invalid.
- R8: Evicting a Modified or Owned line raises `wb_req`. Evicting any line leaves it Invalid and issues no bus command.
- R9: At most one grant is active per cycle, and only to a requesting cache. The search starts at the cache after the last one granted and wraps around.
- R10: For any line, at most one cache is in Modified, Owned or Exclusive. A line in Modified or Exclusive is Invalid in every other cache.
- R11: A read hit in any valid state, a write on Modified and a no-op all issue no bus command. A read hit and a no-op do not change any state.
- R12: A request granted in one cycle appears on the `bus_*`, `mem_abort` and `wb_req` outputs after that rising edge and holds until the next one. The outputs also carry the source index, the line and `bus_vld`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | NCACHE | Request valid per cache |
| cpu_op | input | 2*NCACHE | Op per cache (R2 encoding) |
| cpu_line | input | NCACHE*LW | Line index per cache |
| grant | output | NCACHE | One-hot grant, combinational |
| bus_vld | output | 1 | Registered transaction valid |
| bus_cmd | output | 2 | Registered bus command |
| bus_src | output | SW | Index of requesting cache |
| bus_line | output | LW | Line of the transaction |
| bus_supplier | output | NCACHE | One-hot data-supplying peer |
| mem_abort | output | 1 | Memory read cancelled |
| wb_req | output | 1 | Write-back of evicted dirty line |
| probe_cache | input | SW | Cache selected for probing |
| probe_line | input | LW | Line selected for probing |
| probe_state | output | 3 | State of the probed line |

## Verification
Some conditions are hard to reach from the ports. The supplier priority needs a line held Owned in one cache while other caches hold it Shared. The round-robin order has to be seen while requests contend. A long pseudo-random sequence of requests reaches these on four caches and four lines. It mixes all four ops over a small address space, so lines pass through Owned-with-sharers and Exclusive-then-snooped chains many times. The bench keeps its own state table, which gives the expected bus outputs and the expected state of every line after each request. A separate phase holds every request line high at once to check the grant order.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_state_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_INV  = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } cpu_op_t;

    function automatic logic st_valid(line_state_t s);
        return s != ST_I;
    endfunction

    function automatic logic st_dirty(line_state_t s);
        return (s == ST_M) || (s == ST_O);
    endfunction

    function automatic logic st_unique(line_state_t s);
        return (s == ST_M) || (s == ST_O) || (s == ST_E);
    endfunction
endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_reg_t;

    arb_reg_t arb_d, arb_q;
    logic     found;

    // Search begins at the pointer and wraps; pointer moves past the winner.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        found     = 1'b0;
        arb_d     = arb_q;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = int'(arb_q.ptr) + i;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                grant_idx  = IW'(idx);
            end
        end
        if (found) begin
            arb_d.ptr = (grant_idx == IW'(N - 1)) ? '0 : grant_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_requested_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    p_grant_when_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant));
endmodule

// File: rtl/coh_node.sv
module coh_node
    import coh_pkg::*;
#(
    parameter int LINES = 4,
    parameter int LW    = $clog2(LINES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_vld,
    input  logic        is_req,
    input  logic [LW-1:0] tx_line,
    input  cpu_op_t     tx_op,
    input  bus_cmd_t    snoop_cmd,
    input  logic        peer_valid,
    input  logic [LW-1:0] probe_line,
    output line_state_t snoop_st,
    output line_state_t probe_st
);
    typedef struct packed {
        line_state_t [LINES-1:0] st;
    } node_reg_t;

    node_reg_t   node_d, node_q;
    line_state_t cur_st;
    line_state_t nxt_st;

    assign cur_st   = node_q.st[tx_line];
    assign snoop_st = cur_st;
    assign probe_st = node_q.st[probe_line];

    always_comb begin
        nxt_st = cur_st;
        if (is_req) begin
            unique case (tx_op)
                OP_RD:    if (cur_st == ST_I) nxt_st = peer_valid ? ST_S : ST_E;
                OP_WR:    nxt_st = ST_M;
                OP_EVICT: nxt_st = ST_I;
                default:  nxt_st = cur_st;
            endcase
        end else begin
            unique case (snoop_cmd)
                CMD_RD: begin
                    if (cur_st == ST_M)      nxt_st = ST_O;
                    else if (cur_st == ST_E) nxt_st = ST_S;
                end
                CMD_RDX, CMD_INV: nxt_st = ST_I;
                default: nxt_st = cur_st;
            endcase
        end
        node_d = node_q;
        if (tx_vld) node_d.st[tx_line] = nxt_st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) node_q.st[l] <= ST_I;
        end else begin
            node_q <= node_d;
        end
    end

    p_snoop_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld && !is_req && (snoop_cmd == CMD_RDX || snoop_cmd == CMD_INV))
        |=> node_q.st[$past(tx_line)] == ST_I);
    p_snoop_read_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld && !is_req && snoop_cmd == CMD_RD && st_valid(cur_st))
        |=> st_valid(node_q.st[$past(tx_line)]));
    p_write_ends_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld && is_req && tx_op == OP_WR) |=> node_q.st[$past(tx_line)] == ST_M);
endmodule

// File: rtl/coh_snoop_bus.sv
module coh_snoop_bus
    import coh_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int LINES  = 4,
    parameter int LW     = $clog2(LINES),
    parameter int SW     = $clog2(NCACHE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCACHE-1:0]    cpu_req,
    input  logic [2*NCACHE-1:0]  cpu_op,
    input  logic [NCACHE*LW-1:0] cpu_line,
    output logic [NCACHE-1:0]    grant,
    output logic                 bus_vld,
    output logic [1:0]           bus_cmd,
    output logic [SW-1:0]        bus_src,
    output logic [LW-1:0]        bus_line,
    output logic [NCACHE-1:0]    bus_supplier,
    output logic                 mem_abort,
    output logic                 wb_req,
    input  logic [SW-1:0]        probe_cache,
    input  logic [LW-1:0]        probe_line,
    output logic [2:0]           probe_state
);
    typedef struct packed {
        logic              vld;
        bus_cmd_t          cmd;
        logic [SW-1:0]     src;
        logic [LW-1:0]     line;
        logic [NCACHE-1:0] sup;
        logic              abort;
        logic              wb;
    } bus_reg_t;

    bus_reg_t          bus_d, bus_q;
    logic [SW-1:0]     g_idx;
    logic              tx_vld;
    logic [LW-1:0]     tx_line;
    cpu_op_t           tx_op;
    line_state_t       req_st;
    bus_cmd_t          cmd_c;
    logic              fetch_c;
    logic [NCACHE-1:0] own_f, ex_f, sh_f, val_f, uniq_f, lowest_sh;
    line_state_t       snoop_st [NCACHE];
    line_state_t       probe_all [NCACHE];

    coh_rr_arbiter #(.N(NCACHE), .IW(SW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cpu_req),
        .grant     (grant),
        .grant_idx (g_idx)
    );

    assign tx_vld  = |grant;
    assign tx_line = cpu_line[g_idx*LW +: LW];
    assign tx_op   = cpu_op_t'(cpu_op[g_idx*2 +: 2]);

    for (genvar c = 0; c < NCACHE; c++) begin : g_node
        coh_node #(.LINES(LINES), .LW(LW)) u_node (
            .clk        (clk),
            .rst_n      (rst_n),
            .tx_vld     (tx_vld),
            .is_req     (grant[c]),
            .tx_line    (tx_line),
            .tx_op      (tx_op),
            .snoop_cmd  (cmd_c),
            .peer_valid (|val_f),
            .probe_line (probe_line),
            .snoop_st   (snoop_st[c]),
            .probe_st   (probe_all[c])
        );
    end

    // Peer summary built from the broadcast snoop replies.
    always_comb begin
        for (int c = 0; c < NCACHE; c++) begin
            logic peer;
            peer      = (SW'(c) != g_idx);
            own_f[c]  = peer && st_dirty(snoop_st[c]);
            ex_f[c]   = peer && (snoop_st[c] == ST_E);
            sh_f[c]   = peer && (snoop_st[c] == ST_S);
            val_f[c]  = peer && st_valid(snoop_st[c]);
            uniq_f[c] = st_unique(snoop_st[c]);
        end
        lowest_sh = sh_f & (~sh_f + 1'b1);
    end

    always_comb begin
        req_st = snoop_st[g_idx];
        cmd_c  = CMD_NONE;
        if (tx_vld) begin
            unique case (tx_op)
                OP_RD: if (req_st == ST_I) cmd_c = CMD_RD;
                OP_WR: begin
                    if (req_st == ST_I)                          cmd_c = CMD_RDX;
                    else if (req_st == ST_S || req_st == ST_O)   cmd_c = CMD_INV;
                end
                default: cmd_c = CMD_NONE;
            endcase
        end
        fetch_c = (cmd_c == CMD_RD) || (cmd_c == CMD_RDX);

        bus_d       = '0;
        bus_d.vld   = tx_vld;
        bus_d.cmd   = cmd_c;
        bus_d.src   = g_idx;
        bus_d.line  = tx_line;
        bus_d.abort = fetch_c && (|val_f);
        bus_d.wb    = tx_vld && (tx_op == OP_EVICT) && st_dirty(req_st);
        if (fetch_c) begin
            if (|own_f)     bus_d.sup = own_f;
            else if (|ex_f) bus_d.sup = ex_f;
            else            bus_d.sup = lowest_sh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign bus_vld      = bus_q.vld;
    assign bus_cmd      = bus_q.cmd;
    assign bus_src      = bus_q.src;
    assign bus_line     = bus_q.line;
    assign bus_supplier = bus_q.sup;
    assign mem_abort    = bus_q.abort;
    assign wb_req       = bus_q.wb;
    assign probe_state  = (int'(probe_cache) < NCACHE) ? probe_all[probe_cache] : ST_I;

    p_abort_has_supplier_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort |-> $onehot(bus_supplier));
    p_supplier_is_peer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_vld |-> !bus_supplier[bus_src]);
    p_single_unique_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld |-> $countones(uniq_f) <= 1);
    p_wb_needs_evict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> bus_vld && bus_cmd == CMD_NONE);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_vld |=> !bus_vld && !mem_abort && !wb_req);
endmodule

// File: tb/coh_snoop_bus_test.sv
`timescale 1ns/1ps
module coh_snoop_bus_test;
    localparam int NC = 4;
    localparam int NL = 4;
    localparam int LW = 2;
    localparam int SW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   cpu_req = '0;
    logic [2*NC-1:0] cpu_op = '0;
    logic [NC*LW-1:0] cpu_line = '0;
    logic [NC-1:0]   grant;
    logic            bus_vld;
    logic [1:0]      bus_cmd;
    logic [SW-1:0]   bus_src;
    logic [LW-1:0]   bus_line;
    logic [NC-1:0]   bus_supplier;
    logic            mem_abort;
    logic            wb_req;
    logic [SW-1:0]   probe_cache = '0;
    logic [LW-1:0]   probe_line = '0;
    logic [2:0]      probe_state;

    int checks = 0;
    int errors = 0;
    int mst [NC][NL];
    int rr_ptr = 0;
    bit done = 0;
    int seed = 32'h1d3a;

    always #2.5 clk = ~clk;

    coh_snoop_bus #(.NCACHE(NC), .LINES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
        .cpu_line(cpu_line), .grant(grant), .bus_vld(bus_vld), .bus_cmd(bus_cmd),
        .bus_src(bus_src), .bus_line(bus_line), .bus_supplier(bus_supplier),
        .mem_abort(mem_abort), .wb_req(wb_req), .probe_cache(probe_cache),
        .probe_line(probe_line), .probe_state(probe_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // R2 R4 R7 R10: compare every line of every cache with the model.
    task automatic check_states();
        for (int c = 0; c < NC; c++) begin
            for (int l = 0; l < NL; l++) begin
                probe_cache = SW'(c);
                probe_line  = LW'(l);
                #0.2;
                chk(int'(probe_state) == mst[c][l], "R4_R7 state", int'(probe_state), mst[c][l]);
            end
        end
        for (int l = 0; l < NL; l++) begin
            int nu;
            int ne;
            int nv;
            nu = 0; ne = 0; nv = 0;
            for (int c = 0; c < NC; c++) begin
                if (mst[c][l] >= 2) nu++;
                if (mst[c][l] == 2 || mst[c][l] == 4) ne++;
                if (mst[c][l] != 0) nv++;
            end
            chk(nu <= 1 && (ne == 0 || nv == 1), "R10 single owner", nu, 1);
        end
    endtask

    // Model of one granted request; returns expected bus outputs.
    task automatic model_tx(input int c, input int op, input int ln,
                            output int ecmd, output int esup, output int eab, output int ewb);
        int cur;
        int own;
        int ex;
        int sh;
        bit anyv;
        cur = mst[c][ln];
        own = -1; ex = -1; sh = -1; anyv = 0;
        for (int p = 0; p < NC; p++) begin
            if (p != c) begin
                if (mst[p][ln] == 3 || mst[p][ln] == 4) own = p;
                if (mst[p][ln] == 2) ex = p;
                if (mst[p][ln] == 1 && sh < 0) sh = p;
                if (mst[p][ln] != 0) anyv = 1;
            end
        end
        ecmd = 0;
        if (op == 0 && cur == 0) ecmd = 1;
        if (op == 1) ecmd = (cur == 0) ? 2 : ((cur == 1 || cur == 3) ? 3 : 0);
        esup = 0;
        eab  = 0;
        if (ecmd == 1 || ecmd == 2) begin
            esup = (own >= 0) ? (1 << own) : (ex >= 0) ? (1 << ex) : (sh >= 0) ? (1 << sh) : 0;
            eab  = anyv ? 1 : 0;
        end
        ewb = (op == 2 && (cur == 3 || cur == 4)) ? 1 : 0;
        for (int p = 0; p < NC; p++) begin
            if (p != c) begin
                if (ecmd == 1 && mst[p][ln] == 4) mst[p][ln] = 3;
                else if (ecmd == 1 && mst[p][ln] == 2) mst[p][ln] = 1;
                else if (ecmd == 2 || ecmd == 3) mst[p][ln] = 0;
            end
        end
        if (op == 0 && cur == 0) mst[c][ln] = anyv ? 1 : 2;
        if (op == 1) mst[c][ln] = 4;
        if (op == 2) mst[c][ln] = 0;
        rr_ptr = (c + 1) % NC;
    endtask

    // Checks outputs registered at the last edge (R3 R5 R6 R8 R11 R12).
    task automatic check_bus(input int c, input int ln, input int ecmd, input int esup,
                             input int eab, input int ewb);
        chk(bus_vld == 1'b1, "R12 bus_vld", int'(bus_vld), 1);
        chk(int'(bus_src) == c, "R12 bus_src", int'(bus_src), c);
        chk(int'(bus_line) == ln, "R12 bus_line", int'(bus_line), ln);
        chk(int'(bus_cmd) == ecmd, "R3_R6_R11 bus_cmd", int'(bus_cmd), ecmd);
        chk(int'(bus_supplier) == esup, "R5 supplier", int'(bus_supplier), esup);
        chk(int'(mem_abort) == eab, "R5 mem_abort", int'(mem_abort), eab);
        chk(int'(wb_req) == ewb, "R8 wb_req", int'(wb_req), ewb);
    endtask

    task automatic one_tx(input int c, input int op, input int ln);
        int ecmd;
        int esup;
        int eab;
        int ewb;
        @(negedge clk);
        cpu_req = '0;
        cpu_req[c] = 1'b1;
        cpu_op[c*2 +: 2] = 2'(op);
        cpu_line[c*LW +: LW] = LW'(ln);
        #0.5;
        chk(grant == NC'(1 << c), "R9 grant", int'(grant), 1 << c);
        model_tx(c, op, ln, ecmd, esup, eab, ewb);
        @(negedge clk);
        cpu_req = '0;
        check_bus(c, ln, ecmd, esup, eab, ewb);
        check_states();
    endtask

    function automatic int next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return seed & 32'h7fffffff;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < NL; l++) mst[c][l] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(grant == '0, "R1 grant", int'(grant), 0);
        chk(bus_vld == 1'b0, "R1 bus_vld", int'(bus_vld), 0);
        chk(bus_cmd == 2'd0, "R1 bus_cmd", int'(bus_cmd), 0);
        chk(bus_supplier == '0, "R1 supplier", int'(bus_supplier), 0);
        chk(mem_abort == 1'b0 && wb_req == 1'b0, "R1 abort_wb", int'({mem_abort, wb_req}), 0);
        check_states();

        // Directed chain on line 1: E, snooped to S; M to O; O supplies with sharers.
        one_tx(0, 0, 1);  // R3 miss alone -> E
        one_tx(1, 0, 1);  // R4 E->S, R3 -> S
        one_tx(1, 1, 1);  // R6 S -> INV -> M, R7
        one_tx(2, 0, 1);  // R4 M->O, R5 owner supplies
        one_tx(3, 0, 1);  // R5 owner preferred over sharer
        one_tx(3, 0, 1);  // R11 read hit
        one_tx(3, 3, 1);  // R11 no-op
        one_tx(1, 2, 1);  // R8 evict O -> wb
        one_tx(2, 0, 2);  // R3 -> E
        one_tx(2, 1, 2);  // R6 silent E->M
        one_tx(2, 1, 2);  // R11 write on M
        one_tx(0, 1, 2);  // R6 RDX, R5 supplier
        one_tx(0, 2, 2);  // R8 evict M
        one_tx(3, 2, 1);  // R8 evict S no wb

        // Near-exhaustive pseudo-random sweep over ops, caches and lines.
        for (int n = 0; n < 500; n++) begin
            int r;
            r = next_rand();
            one_tx(r % NC, (r >> 4) % 4, (r >> 8) % NL);
        end

        // R9 contention: every cache reads line 3 at once.
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            cpu_op[c*2 +: 2] = 2'd0;
            cpu_line[c*LW +: LW] = LW'(3);
        end
        cpu_req = '1;
        for (int k = 0; k < NC; k++) begin
            int g;
            int ecmd;
            int esup;
            int eab;
            int ewb;
            g = rr_ptr;
            while (!cpu_req[g]) g = (g + 1) % NC;
            #0.5;
            chk(grant == NC'(1 << g), "R9 round robin", int'(grant), 1 << g);
            model_tx(g, 0, 3, ecmd, esup, eab, ewb);
            @(negedge clk);
            cpu_req[g] = 1'b0;
            check_bus(g, 3, ecmd, esup, eab, ewb);
        end
        check_states();
        @(negedge clk);
        chk(bus_vld == 1'b0, "R12 idle", int'(bus_vld), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule